// File: doc/BRIEF.md
# Keyboard Matrix Scan Interface

This block sits between a key matrix and three byte-wide parallel ports that a processor reads and writes. The matrix has twelve columns of six rows each, plus one standalone key that is not part of the grid. The processor chooses which columns to look at by writing a select byte to the low port and a select nibble to the high port. A zero bit selects its column. It then reads the row port. That port returns the merged, active-low state of the six rows across all selected columns. It also carries the standalone key and the sign of the tape input sample.

The block also supports the opposite direction of scanning. A read of the low port or the high port returns a one-hot-low code. That code marks the lowest-numbered column in that port's group that has any key down, whatever the current selection. Key states arrive as a synchronous bitmap with a one for each pressed key, so debouncing is left to the source. Reads are combinational and valid in the same cycle as the read strobe. Writes take effect on the next clock edge.

Top module: `kbd_matrix_port`

## Requirements
- R1: After reset both select registers hold all ones, so no column is selected, and a row-port read returns ones in bits 7:2 whatever keys are pressed.
- R2: A write to address 0 loads the byte into the select bits of columns 0–7 (bit k selects column k when 0), effective from the next clock edge.
- R3: A write to address 2 loads data bits 3:0 into the select bits of columns 8–11 (bit k selects column 8+k when 0); data bits 7:4 are ignored.
- R4: A read of address 1 returns, in bit 2+r, 0 if row r is pressed in any selected column and 1 otherwise; keys in unselected columns have no effect.
- R5: Bit 1 of an address-1 read is 0 while the standalone key is pressed and 1 otherwise.
- R6: Bit 0 of an address-1 read is 1 when the two's-complement tape sample is non-negative (MSB 0) and 0 when it is negative.
- R7: A read of address 0 returns 0xFF with only bit k cleared, where k is the lowest column among 0–7 with any key pressed; it returns 0xFF if none is pressed, independent of the select registers.
- R8: A read of address 2 returns 0x0F with only bit k cleared, where 8+k is the lowest column among 8–11 with any key pressed; it returns 0x0F if none is pressed. Bits 7:4 are always 0.
- R9: With the read strobe low, read data is 0x00. A read of address 3 returns 0x00. Writes to addresses 1 and 3 change no select state.
- R10: Read data reflects the inputs combinationally in the same cycle as the read strobe, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port address: 0 low select/scan, 1 rows, 2 high select/scan, 3 unused |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, combinational |
| keyMap | input | 72 | Pressed-key bitmap, bit c*6+r is column c row r, 1 = pressed |
| extraKey | input | 1 | Standalone key, 1 = pressed |
| tapeSample | input | 8 | Signed tape input sample |

## Verification
The bench builds the block with its default parameters: eight low columns, four high columns, six rows and an eight-bit tape sample. This exposes the full twelve-column priority order and the boundary between the two select ports. With these sizes every row bit and every column code can be reached by hand-placed key patterns. That includes several keys in one column, keys spread across both port groups, and columns 0, 7, 8 and 11 at the edges of each scan group.

// File: rtl/kbd_pkg.sv
`timescale 1ns/1ps
package kbd_pkg;
  typedef enum logic [1:0] {
    PORT_LO   = 2'd0,
    PORT_ROWS = 2'd1,
    PORT_HI   = 2'd2,
    PORT_NONE = 2'd3
  } portAddr_e;

  typedef struct packed {
    logic wrSelLo;
    logic wrSelHi;
    logic rdScanLo;
    logic rdRows;
    logic rdScanHi;
  } portStrobe_t;
endpackage

// File: rtl/kbd_first_col.sv
`timescale 1ns/1ps
module kbd_first_col #(
  parameter int W = 8
) (
  input  logic [W-1:0] anyKey,
  output logic [W-1:0] code
);
  always_comb begin
    code = '1;
    for (int i = W - 1; i >= 0; i--) begin
      if (anyKey[i]) begin
        code = '1;
        code[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbd_ctrl.sv
`timescale 1ns/1ps
module kbd_ctrl
  import kbd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  output portStrobe_t stb
);
  always_comb begin
    stb = '0;
    unique case (portAddr_e'(addr))
      PORT_LO: begin
        stb.wrSelLo  = wrEn;
        stb.rdScanLo = rdEn;
      end
      PORT_ROWS: stb.rdRows = rdEn;
      PORT_HI: begin
        stb.wrSelHi  = wrEn;
        stb.rdScanHi = rdEn;
      end
      default: stb = '0;
    endcase
  end

  // R9
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdScanLo, stb.rdRows, stb.rdScanHi}));
  // R9
  no_wr_bad_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd1 || addr == 2'd3) |-> !(stb.wrSelLo || stb.wrSelHi));
endmodule

// File: rtl/kbd_datapath.sv
`timescale 1ns/1ps
module kbd_datapath
  import kbd_pkg::*;
#(
  parameter int COLS_LO = 8,
  parameter int COLS_HI = 4,
  parameter int ROWS    = 6,
  parameter int DATA_W  = 8,
  parameter int TAPE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  portStrobe_t               stb,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [(COLS_LO+COLS_HI)*ROWS-1:0] keyMap,
  input  logic                      extraKey,
  input  logic [TAPE_W-1:0]         tapeSample,
  output logic [DATA_W-1:0]         rdData
);
  localparam int COLS = COLS_LO + COLS_HI;

  logic [COLS_LO-1:0] selLo;
  logic [COLS_HI-1:0] selHi;
  logic [COLS-1:0]    selAll;
  logic [COLS-1:0]    colAny;
  logic [ROWS-1:0]    rowOr;
  logic [DATA_W-1:0]  rowsByte;
  logic [COLS_LO-1:0] codeLo;
  logic [COLS_HI-1:0] codeHi;
  logic               unusedBits;

  assign unusedBits = ^{wrData[DATA_W-1:COLS_HI], tapeSample[TAPE_W-2:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selLo <= '1;
      selHi <= '1;
    end else begin
      if (stb.wrSelLo) selLo <= wrData[COLS_LO-1:0];
      if (stb.wrSelHi) selHi <= wrData[COLS_HI-1:0];
    end
  end

  assign selAll = {selHi, selLo};

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign colAny[c] = |keyMap[c*ROWS +: ROWS];
  end

  always_comb begin
    rowOr = '0;
    for (int c = 0; c < COLS; c++) begin
      if (!selAll[c]) rowOr = rowOr | keyMap[c*ROWS +: ROWS];
    end
  end

  assign rowsByte = {~rowOr, ~extraKey, ~tapeSample[TAPE_W-1]};

  kbd_first_col #(.W(COLS_LO)) u_scanLo (.anyKey(colAny[COLS_LO-1:0]), .code(codeLo));
  kbd_first_col #(.W(COLS_HI)) u_scanHi (.anyKey(colAny[COLS-1:COLS_LO]), .code(codeHi));

  always_comb begin
    rdData = '0;
    if (stb.rdScanLo)      rdData = {{(DATA_W-COLS_LO){1'b1}}, codeLo};
    else if (stb.rdRows)   rdData = rowsByte;
    else if (stb.rdScanHi) rdData = {{(DATA_W-COLS_HI){1'b0}}, codeHi};
  end

  // R1
  idle_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdRows && (&selAll)) |-> (&rdData[DATA_W-1:2]));
  // R2
  sel_lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSelLo |=> (selLo == $past(wrData[COLS_LO-1:0])));
  // R3
  sel_hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSelHi |=> (selHi == $past(wrData[COLS_HI-1:0])));
  // R4
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdRows && ((colAny & ~selAll) == '0)) |-> (&rdData[DATA_W-1:2]));
  // R5
  extra_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdRows |-> (rdData[1] == !extraKey));
  // R6
  tape_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdRows |-> (rdData[0] == !tapeSample[TAPE_W-1]));
  // R7
  scan_lo_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdScanLo |-> ($countones(~rdData) <= 1 && ((&rdData) == (colAny[COLS_LO-1:0] == '0))));
  // R8
  scan_hi_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdScanHi |-> (rdData[DATA_W-1:COLS_HI] == '0 && $countones(~rdData[COLS_HI-1:0]) <= 1));
  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rdScanLo || stb.rdRows || stb.rdScanHi) |-> (rdData == '0));
  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrSelLo || stb.wrSelHi) |=> ($stable(selLo) && $stable(selHi)));
endmodule

// File: rtl/kbd_matrix_port.sv
`timescale 1ns/1ps
module kbd_matrix_port
  import kbd_pkg::*;
#(
  parameter int COLS_LO = 8,
  parameter int COLS_HI = 4,
  parameter int ROWS    = 6,
  parameter int DATA_W  = 8,
  parameter int TAPE_W  = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [1:0]                         addr,
  input  logic                               wrEn,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic                               rdEn,
  output logic [DATA_W-1:0]                  rdData,
  input  logic [(COLS_LO+COLS_HI)*ROWS-1:0]  keyMap,
  input  logic                               extraKey,
  input  logic [TAPE_W-1:0]                  tapeSample
);
  portStrobe_t stb;

  kbd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  kbd_datapath #(
    .COLS_LO(COLS_LO), .COLS_HI(COLS_HI), .ROWS(ROWS),
    .DATA_W(DATA_W), .TAPE_W(TAPE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .keyMap(keyMap),
    .extraKey(extraKey), .tapeSample(tapeSample), .rdData(rdData)
  );
endmodule

// File: tb/kbd_matrix_port_test.sv
`timescale 1ns/1ps
module kbd_matrix_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [71:0] keyMap = '0;
  logic        extraKey = 1'b0;
  logic [7:0]  tapeSample = 8'h00;

  int total = 0;
  int failed = 0;
  bit done = 0;
  logic [11:0] tbSel = 12'hFFF;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2 clk = ~clk;

  kbd_matrix_port uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .keyMap(keyMap), .extraKey(extraKey),
    .tapeSample(tapeSample)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRows();
    logic [5:0] acc = '0;
    for (int c = 0; c < 12; c++) if (!tbSel[c]) acc |= keyMap[c*6 +: 6];
    return {~acc, ~extraKey, ~tapeSample[7]};
  endfunction

  function automatic logic [7:0] expLo();
    for (int c = 0; c < 8; c++) if (|keyMap[c*6 +: 6]) return ~(8'h01 << c);
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expHi();
    logic [3:0] m;
    for (int c = 0; c < 4; c++) if (|keyMap[(8+c)*6 +: 6]) begin
      m = 4'h1 << c;
      return {4'h0, ~m};
    end
    return 8'h0F;
  endfunction

  task automatic press(input int col, input int row);
    keyMap[col*6 + row] = 1'b1;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    if (a == 2'd0) tbSel[7:0] = d;
    if (a == 2'd2) tbSel[11:8] = d[3:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: pops expected items and compares in the read cycle (R10)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rdEn) begin
        if (expQ.size() == 0) check("scoreboard underflow", 8'h00, 8'h01);
        else check(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset leaves no column selected
    press(0, 0); press(5, 3);
    doRead(2'd1, 8'hFF, "R1 rows after reset");
    @(negedge clk); #1;
    check("R9 idle bus", rdData, 8'h00);

    // R2 / R4: select column 0
    keyMap = '0; press(0, 0);
    doWrite(2'd0, 8'hFE);
    doRead(2'd1, 8'hFB, "R2 R4 col0 row0");
    // R4: two columns merged
    press(3, 5);
    doWrite(2'd0, 8'hF6);
    doRead(2'd1, expRows(), "R4 cols 0,3 merged");
    // R4: key in unselected column ignored
    press(6, 1);
    doRead(2'd1, expRows(), "R4 unselected col6 ignored");

    // R3: high select, upper bits ignored
    keyMap = '0; press(11, 2);
    doWrite(2'd0, 8'hFF);
    doWrite(2'd2, 8'hF7);
    doRead(2'd1, 8'hEF, "R3 col11 via high port");
    press(8, 4);
    doWrite(2'd2, 8'h0E);
    doRead(2'd1, expRows(), "R3 col8 only");

    // R5 / R6
    extraKey = 1'b1;
    doRead(2'd1, expRows(), "R5 extra key pressed");
    tapeSample = 8'h80;
    doRead(2'd1, expRows(), "R6 tape negative");
    extraKey = 1'b0; tapeSample = 8'h7F;
    doRead(2'd1, expRows(), "R6 tape positive max");

    // R7: low reverse scan
    keyMap = '0; press(3, 1); press(0, 5);
    doRead(2'd0, 8'hFE, "R7 col0 wins over col3");
    keyMap = '0; press(3, 1);
    doRead(2'd0, 8'hF7, "R7 col3");
    keyMap = '0; press(7, 0);
    doRead(2'd0, 8'h7F, "R7 col7");
    keyMap = '0; press(9, 0);
    doRead(2'd0, 8'hFF, "R7 none low");
    doRead(2'd0, expLo(), "R7 model none low");

    // R8: high reverse scan
    keyMap = '0; press(11, 3);
    doRead(2'd2, 8'h07, "R8 col11");
    press(9, 0);
    doRead(2'd2, 8'h0D, "R8 col9 wins over col11");
    keyMap = '0; press(0, 0);
    doRead(2'd2, 8'h0F, "R8 none high");
    press(8, 5);
    doRead(2'd2, expHi(), "R8 col8");

    // R9: writes to address 1 and 3 ignored, address 3 reads zero
    keyMap = '0; press(0, 2); press(10, 1);
    doWrite(2'd0, 8'hFE);
    doWrite(2'd2, 8'h0F);
    doWrite(2'd1, 8'h00);
    doWrite(2'd3, 8'h00);
    doRead(2'd1, 8'hEF, "R9 rows after ignored writes");
    doRead(2'd3, 8'h00, "R9 address 3 read");

    @(negedge clk); @(negedge clk);
    if (expQ.size() != 0) check("R10 scoreboard drained", 8'(expQ.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule